// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block lets an external serial master read and write a small bank of 8-bit registers over a four-signal serial link (active-low select, serial clock, data in, data out). The serial inputs are brought into the system clock domain through synchronizers, and the protocol engine then works on detected clock edges. Each transaction begins with a command byte: a direction flag, an auto-increment flag and a 6-bit register address. One or more data bytes follow.

The register bank holds a read-only identity register and a set of writable control registers. Their contents are exported to the rest of the chip on a flat vector. One bit of the last control register moves the port into 3-wire operation. In that mode read data returns on the shared bidirectional data line instead of the dedicated data-out pin. Both data lines are modelled as a value plus an output enable, so a pad cell outside the block can do the tri-stating.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset every control register holds 00h, `ctrl_o` is all zeros, and both output enables are low.
- R2: The first command bit is the direction (1 = read, 0 = write). The second is the auto-increment flag. The next six bits are the register address, MSB first. A single-byte transfer uses exactly 16 serial clock pulses, and each extra byte adds 8.
- R3: Write data is sampled on rising serial clock edges, MSB first. The addressed register takes the byte once its eighth data bit has been sampled.
- R4: Read data changes on falling serial clock edges, MSB first, and is valid at the following rising edge. The first data bit is driven on the falling edge right after the last address bit.
- R5: With the auto-increment flag at 1, the address advances by one after each data byte and wraps from 3Fh to 00h. With the flag at 0, every byte of the transfer accesses the same register.
- R6: The identity register at address 0Fh reads as the constant 3Bh, and writes to it are ignored.
- R7: Addresses outside 0Fh and 20h–23h read as 00h, and writes to them change no register.
- R8: Bit 0 of the control register at 23h selects 3-wire mode. When it is 1, read data is driven on `sdio_o` with `sdio_oe_o` high and `sdo_oe_o` low. When it is 0, the same holds with the two pins swapped. The two enables are never high together.
- R9: Raising chip select ends the transaction. Both output enables drop, the bit counter restarts, and a partially received data byte is discarded. The next transaction then decodes a fresh command byte.
- R10: `ctrl_o[8*i +: 8]` always equals the control register at address 20h+i and changes only on a completed write to that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial link |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select from the master |
| sck_i | input | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Read data in 4-wire mode |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |
| sdio_o | output | 1 | Read data on the shared line in 3-wire mode |
| sdio_oe_o | output | 1 | Output enable for `sdio_o` |
| ctrl_o | output | 32 | Control registers 20h..23h, register 20h in the low byte |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, four control registers at 20h, the identity register at 0Fh holding 3Bh, and the mode bit at bit 0 of the fourth control register. With the serial clock held at eight system cycles per phase, every edge clears the synchronizers well before the next one. The bench therefore samples read data and enables at the instant a master would. Because the mode bit lies in the randomly written range, the random transfers switch the port between 4-wire and 3-wire operation many times. Auto-increment runs past the top of the control bank and wraps at 3Fh, and both the identity register and unmapped addresses are hit as well.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_reg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_s_i,
  input  logic  sck_s_i,
  input  logic  sdi_s_i,
  input  data_t rd_data_i,
  output addr_t rd_addr_o,
  output logic  wr_en_o,
  output addr_t wr_addr_o,
  output data_t wr_data_o,
  output logic  hdr_done_o,
  output logic  drive_o,
  output logic  dout_o
);
  logic        sck_prev_q;
  logic        rise, fall;
  logic [2:0]  bit_cnt_q;
  logic        hdr_done_q, rw_q, ms_q;
  addr_t       addr_q, hdr_addr, next_addr;
  logic [6:0]  rx_sr_q;
  data_t       tx_sr_q;
  logic        dout_q, drive_q;
  logic        byte_end;

  assign rise     = ~cs_s_i & sck_s_i & ~sck_prev_q;
  assign fall     = ~cs_s_i & ~sck_s_i & sck_prev_q;
  assign byte_end = rise & (bit_cnt_q == 3'd7);
  assign hdr_addr = {rx_sr_q[4:0], sdi_s_i};
  assign next_addr = ms_q ? addr_q + addr_t'(1) : addr_q;

  // prefetch: header end reads the decoded address, byte end reads the next one
  assign rd_addr_o = hdr_done_q ? next_addr : hdr_addr;

  assign wr_en_o   = byte_end & hdr_done_q & ~rw_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = {rx_sr_q, sdi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev_q <= 1'b1;
    else         sck_prev_q <= sck_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      hdr_done_q <= 1'b0;
      rw_q       <= 1'b0;
      ms_q       <= 1'b0;
      addr_q     <= '0;
      rx_sr_q    <= '0;
      tx_sr_q    <= '0;
      dout_q     <= 1'b0;
      drive_q    <= 1'b0;
    end else if (cs_s_i) begin
      bit_cnt_q  <= '0;
      hdr_done_q <= 1'b0;
      dout_q     <= 1'b0;
      drive_q    <= 1'b0;
    end else begin
      if (rise) begin
        bit_cnt_q <= bit_cnt_q + 3'd1;
        rx_sr_q   <= {rx_sr_q[5:0], sdi_s_i};
        if (!hdr_done_q) begin
          if (bit_cnt_q == 3'd0) rw_q <= sdi_s_i;
          if (bit_cnt_q == 3'd1) ms_q <= sdi_s_i;
          if (bit_cnt_q == 3'd7) begin
            addr_q     <= hdr_addr;
            hdr_done_q <= 1'b1;
            tx_sr_q    <= rd_data_i;
          end
        end else if (bit_cnt_q == 3'd7) begin
          addr_q  <= next_addr;
          tx_sr_q <= rd_data_i;
        end
      end
      if (fall && hdr_done_q && rw_q) begin
        dout_q  <= tx_sr_q[DATA_W-1];
        tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
        drive_q <= 1'b1;
      end
    end
  end

  assign hdr_done_o = hdr_done_q;
  assign drive_o    = drive_q;
  assign dout_o     = dout_q;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int    NUM_CTRL  = 4,
  parameter addr_t CTRL_BASE = 6'h20,
  parameter addr_t ID_ADDR   = 6'h0F,
  parameter data_t ID_VALUE  = 8'h3B
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  addr_t                      wr_addr_i,
  input  data_t                      wr_data_i,
  input  addr_t                      rd_addr_i,
  output data_t                      rd_data_o,
  output logic [NUM_CTRL*DATA_W-1:0] ctrl_o
);
  data_t              regs_q [NUM_CTRL];
  logic [NUM_CTRL-1:0] rd_hit;

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    localparam addr_t REG_ADDR = addr_t'(CTRL_BASE + i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == REG_ADDR)    regs_q[i] <= wr_data_i;
    end
    assign rd_hit[i] = (rd_addr_i == REG_ADDR);
    assign ctrl_o[i*DATA_W +: DATA_W] = regs_q[i];
  end

  always_comb begin
    rd_data_o = (rd_addr_i == ID_ADDR) ? ID_VALUE : '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (rd_hit[i]) rd_data_o = regs_q[i];
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int    SYNC_STAGES = 2,
  parameter int    NUM_CTRL    = 4,
  parameter addr_t CTRL_BASE   = 6'h20,
  parameter addr_t ID_ADDR     = 6'h0F,
  parameter data_t ID_VALUE    = 8'h3B,
  parameter int    MODE_REG    = 3,
  parameter int    MODE_BIT    = 0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       sck_i,
  input  logic                       sdi_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  output logic                       sdio_o,
  output logic                       sdio_oe_o,
  output logic [NUM_CTRL*DATA_W-1:0] ctrl_o
);
  localparam int MODE_IDX = MODE_REG * DATA_W + MODE_BIT;

  logic  cs_s, sck_s, sdi_s;
  logic  wr_en, hdr_done, drive, dout, three_wire;
  addr_t wr_addr, rd_addr;
  data_t wr_data, rd_data;

  spi_reg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i, .rst_ni, .d_i(cs_ni), .q_o(cs_s));
  spi_reg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sck (
    .clk_i, .rst_ni, .d_i(sck_i), .q_o(sck_s));
  spi_reg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk_i, .rst_ni, .d_i(sdi_i), .q_o(sdi_s));

  spi_reg_engine u_engine (
    .clk_i, .rst_ni,
    .cs_s_i(cs_s), .sck_s_i(sck_s), .sdi_s_i(sdi_s),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .hdr_done_o(hdr_done), .drive_o(drive), .dout_o(dout));

  spi_reg_bank #(
    .NUM_CTRL(NUM_CTRL), .CTRL_BASE(CTRL_BASE),
    .ID_ADDR(ID_ADDR), .ID_VALUE(ID_VALUE)
  ) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ctrl_o(ctrl_o));

  assign three_wire = ctrl_o[MODE_IDX];
  assign sdo_oe_o   = drive & ~three_wire;
  assign sdio_oe_o  = drive & three_wire;
  assign sdo_o      = sdo_oe_o & dout;
  assign sdio_o     = sdio_oe_o & dout;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int         NUM_CTRL  = 4,
  parameter logic [5:0] CTRL_BASE = 6'h20
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cs_s,
  input logic                  wr_en,
  input logic [5:0]            wr_addr,
  input logic                  hdr_done,
  input logic                  three_wire,
  input logic                  sdo_oe_o,
  input logic                  sdio_oe_o,
  input logic [NUM_CTRL*8-1:0] ctrl_o
);
  logic in_bank;
  assign in_bank = ({1'b0, wr_addr} >= {1'b0, CTRL_BASE}) &&
                   ({1'b0, wr_addr} <  7'({1'b0, CTRL_BASE} + NUM_CTRL));

  p_oe_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdo_oe_o && sdio_oe_o));
  p_oe_three_wire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> three_wire);
  p_oe_four_wire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> !three_wire);
  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (!sdo_oe_o && !sdio_oe_o && !hdr_done));
  p_ctrl_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(ctrl_o));
  p_unmapped_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !in_bank) |=> $stable(ctrl_o));
  p_write_after_hdr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> hdr_done);
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.NUM_CTRL(NUM_CTRL), .CTRL_BASE(CTRL_BASE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .wr_en(wr_en), .wr_addr(wr_addr),
  .hdr_done(hdr_done), .three_wire(three_wire), .sdo_oe_o(sdo_oe_o),
  .sdio_oe_o(sdio_oe_o), .ctrl_o(ctrl_o));

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, sdio, sdio_oe;
  logic [31:0] ctrl;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mreg [4];
  logic [7:0] wdat [4];
  logic [7:0] rdat [4];
  bit oe_bad;

  always #2.5 clk = ~clk;

  spi_reg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sdio_o(sdio), .sdio_oe_o(sdio_oe), .ctrl_o(ctrl));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(logic [5:0] a);
    if (a == 6'h0F) return 8'h3B;
    if (a >= 6'h20 && a <= 6'h23) return mreg[a - 6'h20];
    return 8'h00;
  endfunction

  function automatic logic [31:0] model_ctrl();
    return {mreg[3], mreg[2], mreg[1], mreg[0]};
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // cut > 0 stops after that many bits
  task automatic xfer(bit rw, bit ms, logic [5:0] addr, int nb, int cut);
    logic [7:0] hdr;
    int total;
    bit tw;
    hdr = {rw, ms, addr};
    total = (cut > 0) ? cut : 8 + 8 * nb;
    tw = mreg[3][0];
    oe_bad = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    wait_cyc(HALF);
    for (int i = 0; i < total; i++) begin
      sck = 1'b0;
      if (i < 8) sdi = hdr[7 - i];
      else sdi = rw ? 1'b0 : wdat[(i - 8) / 8][7 - ((i - 8) % 8)];
      wait_cyc(HALF);
      if (rw && i >= 8) begin
        rdat[(i - 8) / 8][7 - ((i - 8) % 8)] = tw ? sdio : sdo;
        if (tw ? !(sdio_oe && !sdo_oe) : !(sdo_oe && !sdio_oe)) oe_bad = 1'b1;
      end
      sck = 1'b1;
      wait_cyc(HALF);
    end
    cs_n = 1'b1;
    wait_cyc(2 * HALF);
    if (!rw) begin
      for (int k = 0; k < nb; k++) begin
        if (8 + 8 * (k + 1) <= total) begin
          logic [5:0] a;
          a = ms ? addr + 6'(k) : addr;
          if (a >= 6'h20 && a <= 6'h23) mreg[a - 6'h20] = wdat[k];
        end
      end
    end
  endtask

  task automatic rd_check(string req, bit ms, logic [5:0] addr, int nb);
    xfer(1'b1, ms, addr, nb, 0);
    for (int k = 0; k < nb; k++)
      chk(req, {24'h0, rdat[k]}, {24'h0, model_rd(ms ? addr + 6'(k) : addr)});
    chk({req, " oe"}, {31'h0, oe_bad}, 32'h0);
    chk("R9 release", {30'h0, sdo_oe, sdio_oe}, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mreg[i] = 8'h00;
    void'($urandom(32'h5A17));
    wait_cyc(4);
    chk("R1 ctrl reset", ctrl, 32'h0);
    chk("R1 oe reset", {30'h0, sdo_oe, sdio_oe}, 32'h0);
    rst_n = 1'b1;
    wait_cyc(4);
    chk("R1 ctrl after release", ctrl, 32'h0);

    // R2 R3 R4: single write then read back
    wdat[0] = 8'hA5;
    xfer(1'b0, 1'b0, 6'h20, 1, 0);
    chk("R3 write 20h", ctrl, model_ctrl());
    rd_check("R4 read 20h", 1'b0, 6'h20, 1);

    // R5: auto-increment write across bank (mode bit kept 0)
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33; wdat[3] = 8'h40;
    xfer(1'b0, 1'b1, 6'h20, 4, 0);
    chk("R10 ctrl after burst", ctrl, 32'h40332211);
    rd_check("R5 burst read", 1'b1, 6'h20, 4);
    rd_check("R5 fixed-address read", 1'b0, 6'h21, 3);
    rd_check("R5 wrap read", 1'b1, 6'h3F, 2);

    // R6 identity
    rd_check("R6 id read", 1'b0, 6'h0F, 1);
    wdat[0] = 8'hFF;
    xfer(1'b0, 1'b0, 6'h0F, 1, 0);
    chk("R6 id write ignored ctrl", ctrl, model_ctrl());
    rd_check("R6 id after write", 1'b0, 6'h0F, 1);

    // R7 unmapped
    wdat[0] = 8'hC3;
    xfer(1'b0, 1'b0, 6'h05, 1, 0);
    chk("R7 unmapped write ctrl", ctrl, model_ctrl());
    rd_check("R7 unmapped read", 1'b0, 6'h05, 1);

    // R8 3-wire
    wdat[0] = 8'h01;
    xfer(1'b0, 1'b0, 6'h23, 1, 0);
    chk("R8 mode bit set", ctrl[24], 1'b1);
    rd_check("R8 3-wire read", 1'b1, 6'h20, 2);
    wdat[0] = 8'h80;
    xfer(1'b0, 1'b0, 6'h23, 1, 0);
    rd_check("R8 back to 4-wire", 1'b0, 6'h23, 1);

    // R9 abort mid data byte, then fresh transaction
    wdat[0] = 8'hEE;
    xfer(1'b0, 1'b0, 6'h21, 1, 12);
    chk("R9 partial byte discarded", ctrl, model_ctrl());
    rd_check("R9 fresh command after abort", 1'b0, 6'h21, 1);
    xfer(1'b1, 1'b0, 6'h20, 1, 13);
    chk("R9 release after aborted read", {30'h0, sdo_oe, sdio_oe}, 32'h0);
    rd_check("R9 read after aborted read", 1'b0, 6'h22, 1);

    // random mix
    for (int t = 0; t < 110; t++) begin
      bit rw, ms;
      logic [5:0] a;
      int nb;
      rw = 1'($urandom);
      ms = 1'($urandom);
      nb = 1 + int'($urandom % 3);
      case ($urandom % 4)
        0: a = 6'h0F;
        1: a = 6'h20 + 6'($urandom % 4);
        2: a = 6'($urandom);
        default: a = 6'h1E + 6'($urandom % 8);
      endcase
      for (int k = 0; k < 4; k++) wdat[k] = 8'($urandom);
      if (rw) rd_check("R4 random read", ms, a, nb);
      else begin
        xfer(1'b0, ms, a, nb, 0);
        chk("R10 random write ctrl", ctrl, model_ctrl());
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule